// File: doc/BRIEF.md
# Serial Character Transmitter with Preamble and Break

This block drives one asynchronous serial line. A byte written into its single holding register is moved into a shift register at the next bit boundary and sent as a ten-bit character: a low start bit, the data bits least significant first, and a high stop bit. Bit timing comes from an external one-cycle tick that marks each bit period, so the block has no baud-rate divider of its own.

Two control bits steer the line. These are the transmitter enable and the break request, and both are written together through one strobe. A write reaches them only while the module-wide enable input is high. A rising transmitter enable queues one all-ones character, which serves as a wake-up preamble, or as an idle gap when the enable is dropped and raised again during a character. Dropping the enable lets the character in flight finish and then holds the line high. A break request sends all-zero characters, and then one forced high bit once the request is gone.

At each bit boundary the next frame is chosen in a fixed order. A break comes first, then the high bit that follows a break, then a queued all-ones character, then buffered data. Two flags report progress: one shows that the holding register is empty, the other that the line is idle with nothing left to send.

Top module: `uart_pb_tx`

## Requirements
- R1: After reset, and whenever no frame is being shifted, `txd` is 1. Reset leaves `tx_empty` = 1, `tx_done` = 1, and the enable and break bits cleared.
- R2: A data frame is 10 bit periods long: a 0, then `dat_in` bit 0 through bit 7, then a 1. `txd` changes only on a clock edge where `bit_tick` is 1.
- R3: A control write that takes the transmitter enable from 0 to 1 queues one character of ten 1 bits. That character is sent before any byte already waiting in the holding register.
- R4: A control write is ignored while `mod_en` is 0. A byte written afterwards therefore stays in the holding register, and `tx_empty` stays 0.
- R5: Clearing the transmitter enable during a frame lets that frame finish, after which `txd` stays 1. A byte written meanwhile is held until the enable is set again.
- R6: Clearing and then setting the enable while a frame is in flight queues one ten-bit all-ones character. It follows the current frame and comes ahead of newly buffered data.
- R7: Setting and then clearing the break bit between two ticks sends ten 0 bits followed by exactly one 1 bit.
- R8: While the break bit stays set, break characters follow one another with no 1 bit between them. After release, one 1 bit follows the last break.
- R9: A break requested after an enable rise, but before the preamble has started, is sent instead of the preamble. Data written in the same bit period starts straight after the single 1 bit that follows the break.
- R10: `tx_empty` goes to 0 in the cycle after `dat_wr`. It returns to 1 on the tick edge at which the byte is moved into the shift register.
- R11: `tx_done` is 1 only when no frame is being shifted and nothing is waiting: no byte, no queued character, no break and no pending high bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse marking each bit period |
| mod_en | input | 1 | Module enable; a control write is accepted only while this is high |
| ctl_wr | input | 1 | Control write strobe |
| ctl_te | input | 1 | Transmitter enable value written by `ctl_wr` |
| ctl_brk | input | 1 | Break request value written by `ctl_wr` |
| dat_wr | input | 1 | Data write strobe |
| dat_in | input | DATA_W | Byte to transmit |
| txd | output | 1 | Serial output line, idle high |
| tx_empty | output | 1 | Holding register is empty |
| tx_done | output | 1 | Line idle with nothing pending |

## Verification
Frame selection happens only on tick edges. The first bit of a new frame therefore shows on `txd` just after the first tick edge that follows the request, and each later bit appears one tick period after the one before it.

The driver applies every control or data write at a falling edge and finishes it within the same bit period. At that moment it appends the exact bits that must appear to a scoreboard queue. A monitor samples `txd` one time unit after each tick edge and compares the sample with the head of the queue, or with 1 when the queue is empty.

`tx_empty` is checked one cycle after a data write and again just after the tick edge that moves the byte. `tx_done` is checked once the queue has drained.

// File: rtl/uart_pb_tx_pkg.sv
package uart_pb_tx_pkg;

   // Frame kinds, chosen at each bit boundary
   typedef enum logic [2:0] {
      FK_NONE  = 3'd0,
      FK_BREAK = 3'd1,
      FK_MARK  = 3'd2,
      FK_IDLE  = 3'd3,
      FK_DATA  = 3'd4
   } frame_kind_e;

endpackage

// File: rtl/tx_ctrl_regs.sv
module tx_ctrl_regs (
   input  logic clk,
   input  logic rst_n,
   input  logic mod_en,
   input  logic ctl_wr,
   input  logic ctl_te,
   input  logic ctl_brk,
   input  logic clr_idle,
   input  logic clr_brk,
   output logic te_q,
   output logic sbk_q,
   output logic idle_pend,
   output logic brk_pend
);

   logic wr_ok, te_rise, brk_rise;

   assign wr_ok    = ctl_wr && mod_en;
   assign te_rise  = wr_ok && ctl_te && !te_q;
   assign brk_rise = wr_ok && ctl_brk && !sbk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         te_q      <= 1'b0;
         sbk_q     <= 1'b0;
         idle_pend <= 1'b0;
         brk_pend  <= 1'b0;
      end else begin
         if (wr_ok) begin
            te_q  <= ctl_te;
            sbk_q <= ctl_brk;
         end
         if (te_rise)
            idle_pend <= 1'b1;
         else if (clr_idle)
            idle_pend <= 1'b0;
         if (brk_rise)
            brk_pend <= 1'b1;
         else if (clr_brk)
            brk_pend <= 1'b0;
      end
   end

endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              take,
   output logic [DATA_W-1:0] rdata,
   output logic              full
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         full  <= 1'b0;
      end else begin
         if (wr) begin
            rdata <= wdata;
            full  <= 1'b1;
         end else if (take) begin
            full  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tx_frame_pick.sv
module tx_frame_pick
   import uart_pb_tx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        boundary,
   input  logic        te_q,
   input  logic        sbk_q,
   input  logic        brk_pend,
   input  logic        idle_pend,
   input  logic        buf_full,
   output frame_kind_e pick,
   output logic        mark_pend
);

   always_comb begin
      if (!te_q)
         pick = FK_NONE;
      else if (sbk_q || brk_pend)
         pick = FK_BREAK;
      else if (mark_pend)
         pick = FK_MARK;
      else if (idle_pend)
         pick = FK_IDLE;
      else if (buf_full)
         pick = FK_DATA;
      else
         pick = FK_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mark_pend <= 1'b0;
      else if (boundary) begin
         if (pick == FK_BREAK)
            mark_pend <= 1'b1;
         else if (pick == FK_MARK)
            mark_pend <= 1'b0;
      end
   end

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
   parameter int FRAME_W = 10,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   input  logic [CNT_W-1:0]   load_len,
   output logic               busy,
   output logic               last,
   output logic               txd
);

   logic [FRAME_W-1:0] sh;
   logic [CNT_W-1:0]   cnt;

   assign last = busy && (cnt == CNT_W'(1));
   assign txd  = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         cnt  <= '0;
         busy <= 1'b0;
      end else if (bit_tick) begin
         if (load) begin
            sh   <= load_word;
            cnt  <= load_len;
            busy <= 1'b1;
         end else if (busy) begin
            if (last)
               busy <= 1'b0;
            else begin
               sh  <= {1'b1, sh[FRAME_W-1:1]};
               cnt <= cnt - CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/uart_pb_tx.sv
module uart_pb_tx
   import uart_pb_tx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              mod_en,
   input  logic              ctl_wr,
   input  logic              ctl_te,
   input  logic              ctl_brk,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] dat_in,
   output logic              txd,
   output logic              tx_empty,
   output logic              tx_done
);

   localparam int FRAME_W = DATA_W + 2;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("uart_pb_tx: DATA_W must lie in 5..9");
   end

   logic              te_q, sbk_q, idle_pend, brk_pend;
   logic [DATA_W-1:0] buf_data, ordered;
   logic              buf_full;
   logic              sh_busy, sh_last;
   logic              boundary, load, take_data, clr_idle, clr_brk;
   logic              mark_pend;
   frame_kind_e       pick;
   logic [FRAME_W-1:0] word;
   logic [CNT_W-1:0]   len;

   assign boundary  = bit_tick && (!sh_busy || sh_last);
   assign load      = boundary && (pick != FK_NONE);
   assign take_data = boundary && (pick == FK_DATA);
   assign clr_brk   = boundary && (pick == FK_BREAK);
   assign clr_idle  = boundary && (pick == FK_BREAK || pick == FK_IDLE);

   tx_ctrl_regs u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .mod_en    (mod_en),
      .ctl_wr    (ctl_wr),
      .ctl_te    (ctl_te),
      .ctl_brk   (ctl_brk),
      .clr_idle  (clr_idle),
      .clr_brk   (clr_brk),
      .te_q      (te_q),
      .sbk_q     (sbk_q),
      .idle_pend (idle_pend),
      .brk_pend  (brk_pend)
   );

   tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (dat_wr),
      .wdata (dat_in),
      .take  (take_data),
      .rdata (buf_data),
      .full  (buf_full)
   );

   tx_frame_pick u_pick (
      .clk       (clk),
      .rst_n     (rst_n),
      .boundary  (boundary),
      .te_q      (te_q),
      .sbk_q     (sbk_q),
      .brk_pend  (brk_pend),
      .idle_pend (idle_pend),
      .buf_full  (buf_full),
      .pick      (pick),
      .mark_pend (mark_pend)
   );

   // Bit order of the payload
   if (MSB_FIRST) begin : g_msb
      for (genvar i = 0; i < DATA_W; i++) begin : g_rev
         assign ordered[i] = buf_data[DATA_W-1-i];
      end
   end else begin : g_lsb
      assign ordered = buf_data;
   end

   always_comb begin
      word = '1;
      len  = CNT_W'(FRAME_W);
      unique case (pick)
         FK_BREAK: word = '0;
         FK_MARK:  len  = CNT_W'(1);
         FK_DATA:  word = {1'b1, ordered, 1'b0};
         default:  word = '1;
      endcase
   end

   tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_tick  (bit_tick),
      .load      (load),
      .load_word (word),
      .load_len  (len),
      .busy      (sh_busy),
      .last      (sh_last),
      .txd       (txd)
   );

   assign tx_empty = !buf_full;
   assign tx_done  = !sh_busy && !buf_full && !idle_pend && !brk_pend
                     && !mark_pend && !sbk_q;

endmodule

// File: rtl/uart_pb_tx_chk.sv
module uart_pb_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic mod_en,
   input logic ctl_wr,
   input logic dat_wr,
   input logic txd,
   input logic tx_empty,
   input logic tx_done,
   input logic te_q,
   input logic busy
);

   a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable(txd));

   a_r4_locked_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !mod_en) |=> $stable(te_q));

   a_r10_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      dat_wr |=> !tx_empty);

   a_r10_empties_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(bit_tick));

   a_r11_done_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (txd && !busy));

endmodule

bind uart_pb_tx uart_pb_tx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_tick (bit_tick),
   .mod_en   (mod_en),
   .ctl_wr   (ctl_wr),
   .dat_wr   (dat_wr),
   .txd      (txd),
   .tx_empty (tx_empty),
   .tx_done  (tx_done),
   .te_q     (te_q),
   .busy     (sh_busy)
);

// File: tb/sim_uart_pb_tx.sv
module sim_uart_pb_tx;

   localparam int CLK_P = 10;
   localparam int DIV   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mod_en = 1'b0;
   logic       ctl_wr = 1'b0, ctl_te = 1'b0, ctl_brk = 1'b0;
   logic       dat_wr = 1'b0;
   logic [7:0] dat_in = '0;
   logic       txd, tx_empty, tx_done;
   logic [3:0] tcnt;
   logic       tick;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   bit    exp_q[$];
   string tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) tcnt <= '0;
      else        tcnt <= (tcnt == 4'(DIV-1)) ? '0 : tcnt + 4'd1;
   end
   assign tick = rst_n && (tcnt == 4'(DIV-1));

   uart_pb_tx u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(tick), .mod_en(mod_en),
      .ctl_wr(ctl_wr), .ctl_te(ctl_te), .ctl_brk(ctl_brk),
      .dat_wr(dat_wr), .dat_in(dat_in),
      .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Monitor: compare each bit against the scoreboard head
   always @(posedge clk) begin
      if (rst_n && tick && !finished) begin
         bit    e;
         string t;
         #1;
         if (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
         end else begin
            e = 1'b1;
            t = "R1";
         end
         chk(txd == e, t, int'(txd), int'(e));
      end
   end

   task automatic push_bits(input bit v, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(v);
         tag_q.push_back(tag);
      end
   endtask

   task automatic push_frame(input logic [7:0] b, input string tag);
      push_bits(1'b0, 1, tag);
      for (int i = 0; i < 8; i++) push_bits(b[i], 1, tag);
      push_bits(1'b1, 1, tag);
   endtask

   task automatic wait_tick();
      @(posedge clk iff tick);
      @(negedge clk);
   endtask

   task automatic ctl_write(input bit te, input bit brk);
      ctl_wr = 1'b1; ctl_te = te; ctl_brk = brk;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic dat_write(input logic [7:0] b);
      dat_wr = 1'b1; dat_in = b;
      @(negedge clk);
      dat_wr = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      wait_tick();
      wait_tick();
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(txd == 1'b1, "R1", int'(txd), 1);
      chk(tx_empty == 1'b1, "R1", int'(tx_empty), 1);
      chk(tx_done == 1'b1, "R1", int'(tx_done), 1);
      rst_n = 1'b1;
      wait_tick();

      // R4: control write ignored while module disabled
      ctl_write(1'b1, 1'b0);
      dat_write(8'hA5);
      chk(tx_empty == 1'b0, "R10", int'(tx_empty), 0);
      repeat (3) wait_tick();
      chk(tx_empty == 1'b0, "R4", int'(tx_empty), 0);

      // R3: enable rise sends preamble ahead of waiting byte
      mod_en = 1'b1;
      ctl_write(1'b1, 1'b0);
      push_bits(1'b1, 10, "R3");
      push_frame(8'hA5, "R2");
      drain();
      chk(tx_done == 1'b1, "R11", int'(tx_done), 1);
      chk(tx_empty == 1'b1, "R10", int'(tx_empty), 1);

      // R10: empty flag timing
      dat_write(8'h3C);
      chk(tx_empty == 1'b0, "R10", int'(tx_empty), 0);
      chk(tx_done == 1'b0, "R11", int'(tx_done), 0);
      push_frame(8'h3C, "R2");
      wait_tick();
      chk(tx_empty == 1'b1, "R10", int'(tx_empty), 1);
      dat_write(8'h81);
      push_frame(8'h81, "R2");
      drain();

      // R5: graceful disable, byte held
      dat_write(8'h5A);
      push_frame(8'h5A, "R5");
      repeat (3) wait_tick();
      ctl_write(1'b0, 1'b0);
      dat_write(8'hC3);
      drain();
      repeat (3) wait_tick();
      chk(tx_empty == 1'b0, "R5", int'(tx_empty), 0);
      ctl_write(1'b1, 1'b0);
      push_bits(1'b1, 10, "R3");
      push_frame(8'hC3, "R5");
      drain();

      // R6: enable toggle mid-character queues idle character
      dat_write(8'h96);
      push_frame(8'h96, "R2");
      repeat (4) wait_tick();
      ctl_write(1'b0, 1'b0);
      ctl_write(1'b1, 1'b0);
      push_bits(1'b1, 10, "R6");
      dat_write(8'h0F);
      push_frame(8'h0F, "R6");
      drain();

      // R7: break pulse
      ctl_write(1'b1, 1'b1);
      ctl_write(1'b1, 1'b0);
      push_bits(1'b0, 10, "R7");
      push_bits(1'b1, 1, "R7");
      dat_write(8'h42);
      push_frame(8'h42, "R7");
      drain();

      // R8: held break, back to back
      ctl_write(1'b1, 1'b1);
      push_bits(1'b0, 20, "R8");
      repeat (15) wait_tick();
      ctl_write(1'b1, 1'b0);
      push_bits(1'b1, 1, "R8");
      dat_write(8'hE7);
      push_frame(8'hE7, "R8");
      drain();
      chk(tx_done == 1'b1, "R11", int'(tx_done), 1);

      // R9: break before preamble replaces it
      ctl_write(1'b0, 1'b0);
      drain();
      ctl_write(1'b1, 1'b0);
      ctl_write(1'b1, 1'b1);
      ctl_write(1'b1, 1'b0);
      dat_write(8'h6D);
      push_bits(1'b0, 10, "R9");
      push_bits(1'b1, 1, "R9");
      push_frame(8'h6D, "R9");
      drain();
      chk(tx_done == 1'b1, "R11", int'(tx_done), 1);
      chk(txd == 1'b1, "R1", int'(txd), 1);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule